// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block turns a 64-bit session key and a 22-bit frame number into a burst of stream-cipher keystream bits. It holds three linear feedback shift registers of different lengths. During loading, all three move on every cycle. During generation, each cycle only the registers that agree with a majority vote of their clocking bits advance.

A single `start` pulse samples the key and frame number as parallel words. It then runs three phases in order. First, an 86-cycle load phase mixes in the key bits and then the frame-number bits, least significant bit first. Second, a 100-cycle warm-up phase runs under majority clocking and produces no output. Third, the block emits 228 keystream bits, one per cycle. The first 114 bits are tagged as the uplink half and the last 114 as the downlink half. A `done` flag follows the last bit. Combining the keystream with data and advancing the frame number between bursts are left to the surrounding logic.

Top module: `stopgo_keystream`

## Requirements
- R1: The registers are 19, 22 and 23 bits long. Their feedback is the XOR of bits {13,16,17,18}, {20,21} and {7,20,21,22} respectively. Each step shifts the register left by one and places the feedback at bit 0.
- R2: An accepted `start` clears all three registers and latches `key` and `iv`. For the next 86 cycles every register steps, with the incoming bit also XORed with key bit 0..63 and then iv bit 0..21, one bit per cycle.
- R3: After loading, the clocking bits are bit 8, bit 10 and bit 10 of the 19-, 22- and 23-bit registers. Only the registers whose clocking bit equals the majority of the three advance, so at least two step every cycle.
- R4: 100 majority-clocked warm-up cycles follow loading and produce no valid output. The first `ks_valid` is seen 187 clock edges after the edge that accepted `start`.
- R5: Each keystream bit is the XOR of bit 18, bit 21 and bit 22 of the three registers, taken after that cycle's step.
- R6: Exactly 228 keystream bits appear, with `ks_valid` high for 228 consecutive cycles. `ks_dir` is 0 (uplink) for bits 0..113 and 1 (downlink) for bits 114..227.
- R7: `busy` is high from the cycle after an accepted `start` until `done` rises. `done` rises one cycle after the last valid bit and stays high until the next accepted `start`.
- R8: A `start` received while `busy` is high is ignored: the burst in progress and its output are unchanged. No further bits appear after `done` without a new `start`.
- R9: With `rst_n` low at a clock edge, the block returns to idle. Its registers are cleared and `busy`, `done`, `ks_valid`, `ks_bit` and `ks_dir` all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a burst when the block is idle |
| key | input | 64 | Session key, sampled on an accepted start |
| iv | input | 22 | Frame number, sampled on an accepted start |
| busy | output | 1 | A burst is in progress |
| ks_valid | output | 1 | `ks_bit` carries a keystream bit this cycle |
| ks_bit | output | 1 | Keystream bit |
| ks_dir | output | 1 | 0 = uplink half, 1 = downlink half |
| done | output | 1 | Last burst completed |

## Verification
A single wrong bit or a missed step in any register reaches the keystream within one register length: at most 23 steps for a corrupted bit to shift to the MSB. It also changes later majority votes, so the rest of the burst diverges from the expected sequence. A load-phase fault, such as a wrong bit order or a wrong tap, therefore shows up somewhere in the 228 output bits of nearly every key/IV pair. Sweeping one-hot key and IV words exposes each load position individually. Phase-length errors appear at once as a shifted first-valid cycle or a wrong `done` cycle.

// File: rtl/stopgo_pkg.sv
// Shared definitions for the majority-clocked keystream generator.
// Assumes exactly three registers; each mask is held in 32 bits.
package stopgo_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_WARM,
        PH_RUN,
        PH_FIN
    } phase_e;

    localparam int NREG = 3;
    localparam int REG_LEN [NREG] = '{19, 22, 23};
    localparam logic [31:0] REG_TAPS [NREG] = '{32'h0007_2000, 32'h0030_0000, 32'h0070_0080};
    localparam int REG_CLK [NREG] = '{8, 10, 10};
endpackage

// File: rtl/lfsr_stage.sv
// One stop/go shift register. On step it shifts left and takes the XOR of
// its tapped bits and in_bit at bit 0. It reports its clocking bit and the
// value its MSB will hold after this cycle. Assumes LEN >= 2 and CLK_POS < LEN.
module lfsr_stage #(
    parameter int          LEN     = 19,
    parameter logic [31:0] TAPS    = 32'h0007_2000,
    parameter int          CLK_POS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic in_bit,
    output logic msb_next,
    output logic clk_bit
);
    localparam logic [LEN-1:0] MASK = TAPS[LEN-1:0];

    logic [LEN-1:0] st_q;
    logic           fb;

    // Feedback value entering at bit 0.
    always_comb fb = (^(st_q & MASK)) ^ in_bit;

    // State register: cleared on reset or clear, shifted on step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q <= '0;
        end else if (step) begin
            st_q <= {st_q[LEN-2:0], fb};
        end
    end

    // Look-ahead MSB and clocking-bit outputs.
    always_comb begin
        msb_next = step ? st_q[LEN-2] : st_q[LEN-1];
        clk_bit  = st_q[CLK_POS];
    end

    // R3: a register that is not stepped holds its value.
    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(st_q));

    // R1: a step moves every bit one place toward the MSB.
    p_shift_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (st_q[LEN-1:1] == $past(st_q[LEN-2:0])));
endmodule

// File: rtl/seq_ctrl.sv
// Phase sequencer: idle -> load -> warm-up -> run -> finish -> idle.
// Accepts start only in idle. Counts the cycles of each phase and keeps
// done set from burst end until the next accepted start.
module seq_ctrl
    import stopgo_pkg::*;
#(
    parameter int LOAD_CYC = 86,
    parameter int WARM_CYC = 100,
    parameter int BURST    = 228,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          accept,
    output logic          done
);
    // Start is only honoured while idle.
    always_comb accept = start && (phase == PH_IDLE);

    // Phase, counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_LOAD;
                    cnt   <= '0;
                    done  <= 1'b0;
                end
                PH_LOAD: if (cnt == CW'(LOAD_CYC - 1)) begin
                    phase <= PH_WARM;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_WARM: if (cnt == CW'(WARM_CYC - 1)) begin
                    phase <= PH_RUN;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_RUN: if (cnt == CW'(BURST - 1)) begin
                    phase <= PH_FIN;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    // R8: load is never re-entered from a busy phase.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && phase != PH_LOAD) |=> (phase != PH_LOAD));

    // R7: done is only ever seen while idle.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE));
endmodule

// File: rtl/stopgo_keystream.sv
// Majority-clocked three-register keystream generator (top).
// Latches key and iv on an accepted start, loads them LSB first with
// regular clocking, warms up under majority clocking, then emits BURST
// bits split into two direction halves. Assumes BURST is even.
module stopgo_keystream
    import stopgo_pkg::*;
#(
    parameter int KEY_BITS   = 64,
    parameter int IV_BITS    = 22,
    parameter int WARM_CYC   = 100,
    parameter int BURST_BITS = 228
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [KEY_BITS-1:0] key,
    input  logic [IV_BITS-1:0]  iv,
    output logic                busy,
    output logic                ks_valid,
    output logic                ks_bit,
    output logic                ks_dir,
    output logic                done
);
    localparam int LD_BITS = KEY_BITS + IV_BITS;
    localparam int HALF    = BURST_BITS / 2;
    localparam int MAX_A   = (LD_BITS > WARM_CYC) ? LD_BITS : WARM_CYC;
    localparam int MAXC    = (MAX_A > BURST_BITS) ? MAX_A : BURST_BITS;
    localparam int CW      = $clog2(MAXC + 1);

    phase_e              phase;
    logic [CW-1:0]       cnt;
    logic                accept;
    logic [LD_BITS-1:0]  ld_q;
    logic [NREG-1:0]     step;
    logic [NREG-1:0]     cbit;
    logic [NREG-1:0]     nmsb;
    logic                maj;
    logic                in_bit;

    seq_ctrl #(
        .LOAD_CYC (LD_BITS),
        .WARM_CYC (WARM_CYC),
        .BURST    (BURST_BITS),
        .CW       (CW)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .cnt    (cnt),
        .accept (accept),
        .done   (done)
    );

    // Load shifter: key then iv, consumed from bit 0 one per load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else if (accept) begin
            ld_q <= {iv, key};
        end else if (phase == PH_LOAD) begin
            ld_q <= ld_q >> 1;
        end
    end

    // Step enables: all during load, majority agreement during warm-up/run.
    always_comb begin
        maj    = (cbit[0] & cbit[1]) | (cbit[0] & cbit[2]) | (cbit[1] & cbit[2]);
        in_bit = (phase == PH_LOAD) ? ld_q[0] : 1'b0;
        for (int i = 0; i < NREG; i++) begin
            step[i] = (phase == PH_LOAD) ||
                      (((phase == PH_WARM) || (phase == PH_RUN)) && (cbit[i] == maj));
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        lfsr_stage #(
            .LEN     (REG_LEN[g]),
            .TAPS    (REG_TAPS[g]),
            .CLK_POS (REG_CLK[g])
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (accept),
            .step     (step[g]),
            .in_bit   (in_bit),
            .msb_next (nmsb[g]),
            .clk_bit  (cbit[g])
        );
    end

    // Output register: one keystream bit per run cycle with its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_valid <= 1'b0;
            ks_bit   <= 1'b0;
            ks_dir   <= 1'b0;
        end else begin
            ks_valid <= (phase == PH_RUN);
            if (phase == PH_RUN) begin
                ks_bit <= ^nmsb;
                ks_dir <= (cnt >= CW'(HALF));
            end
        end
    end

    // Busy whenever the sequencer has left idle.
    always_comb busy = (phase != PH_IDLE);

    // R3: majority clocking always moves at least two registers.
    p_two_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_WARM) || (phase == PH_RUN)) |-> ($countones(step) >= 2));

    // R6: valid bits only appear inside a burst.
    p_valid_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> busy);

    // R6: the switch to the downlink half happens mid-burst.
    p_dir_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_dir) |-> (ks_valid && $past(ks_valid)));

    // R7: once done, the block is quiet.
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ks_valid && !busy));
endmodule

// File: tb/stopgo_keystream_tb.sv
`timescale 1ns/1ps
module stopgo_keystream_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] key = '0;
    logic [21:0] iv = '0;
    logic        busy, ks_valid, ks_bit, ks_dir, done;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_ks [228];

    always #2 clk = ~clk;

    stopgo_keystream u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .busy(busy), .ks_valid(ks_valid), .ks_bit(ks_bit), .ks_dir(ks_dir), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of R1..R5: fills exp_ks with the 228 expected bits.
    task automatic build_model(input logic [63:0] k, input logic [21:0] v);
        logic [18:0] a;
        logic [21:0] b;
        logic [22:0] c;
        logic ib, ca, cb, cc, m;
        a = '0; b = '0; c = '0;
        for (int i = 0; i < 86; i++) begin
            ib = (i < 64) ? k[i] : v[i - 64];
            a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13] ^ ib};
            b = {b[20:0], b[21] ^ b[20] ^ ib};
            c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7] ^ ib};
        end
        for (int i = 0; i < 328; i++) begin
            ca = a[8]; cb = b[10]; cc = c[10];
            m = (ca & cb) | (ca & cc) | (cb & cc);
            if (ca == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
            if (cb == m) b = {b[20:0], b[21] ^ b[20]};
            if (cc == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
            if (i >= 100) exp_ks[i - 100] = a[18] ^ b[21] ^ c[22];
        end
    endtask

    // One full burst; inject = pulse a second start mid-burst (R8).
    task automatic run_burst(input logic [63:0] k, input logic [21:0] v, input bit inject);
        int lat;
        int nv;
        int prev;
        build_model(k, v);
        @(negedge clk);
        key = k; iv = v; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1; nv = 0; prev = 0;
        check(busy === 1'b1 && done === 1'b0, "R7", "busy/done after accept", {busy, done}, 2);
        while (!done && lat < 1200) begin
            if (ks_valid) begin
                if (nv == 0) check(lat == 188, "R4", "first valid cycle", lat, 188);
                else check(lat == prev + 1, "R6", "valid contiguity", lat, prev + 1);
                if (nv < 228) begin
                    check(ks_bit == exp_ks[nv], "R5", $sformatf("bit %0d", nv), ks_bit, exp_ks[nv]);
                    check(ks_dir == (nv >= 114), "R6", $sformatf("dir of bit %0d", nv), ks_dir, nv >= 114);
                end
                prev = lat;
                nv++;
            end
            if (inject && lat == 200) begin
                start = 1'b1; key = ~k; iv = ~v;
            end
            if (inject && lat == 201) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(nv == 228, "R6", "valid bit count", nv, 228);
        check(lat == 416, "R7", "done cycle", lat, 416);
        check(busy == 1'b0, "R7", "busy at done", busy, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ks_valid == 1'b0 && done == 1'b1, "R8", "quiet after done", {ks_valid, done}, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0 && done == 0 && ks_valid == 0 && ks_bit == 0 && ks_dir == 0,
              "R9", "reset outputs", {busy, done, ks_valid, ks_bit, ks_dir}, 0);
        rst_n = 1'b1;

        run_burst(64'h0, 22'h0, 1'b0);
        run_burst({64{1'b1}}, {22{1'b1}}, 1'b0);
        run_burst(64'h0123_4567_89AB_CDEF, 22'h134, 1'b0);
        run_burst(64'hFEDC_BA98_7654_3210, 22'h2A5A5, 1'b1);   // R8 ignored start

        // R2: one-hot IV sweep and sampled one-hot key positions.
        for (int j = 0; j < 22; j++) run_burst(64'h0, 22'(1) << j, 1'b0);
        for (int j = 0; j < 64; j += 9) run_burst(64'(1) << j, 22'h0, 1'b0);
        run_burst(64'(1) << 63, 22'h0, 1'b0);

        // R9: reset in the middle of a burst.
        @(negedge clk);
        key = 64'hA5A5_5A5A_0F0F_F0F0; iv = 22'h15555; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (250) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && ks_valid == 0 && ks_bit == 0 && ks_dir == 0,
              "R9", "mid-burst reset outputs", {busy, done, ks_valid, ks_bit, ks_dir}, 0);
        rst_n = 1'b1;
        run_burst(64'h1357_9BDF_2468_ACE0, 22'h3F00F, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule